// File: doc/BRIEF.md
# H-Bridge Drive Mode Decoder

This block turns the logic-level commands of a brushed DC motor drive into on/off commands for the four power switches of a full bridge. A direction bit, an enable bit, a decay-mode bit and a chop request from the current regulator pick one of the drive, brake, fast-decay or mixed-decay patterns. An active-low standby input and a disable input from the protection logic force the whole bridge to high impedance. A zero-current flag lets the bridge release to high impedance once fast-decay current has died away.

Each of the two legs (leg A, bit 0 of every leg vector; leg B, bit 1) has a sequencer that owns its high-side and low-side switch. Turning a switch off takes effect at the next clock edge. Turning a switch on waits until both switches of that leg have been off for a programmable number of cycles, which keeps the crossover current out of the leg. All outputs are registered. A leg that has been off long enough follows a changed command at the next rising clock edge.

Top module: `hbridge_mode_decoder`

## Requirements
- R1: With standby high, disable low, enable high and no chop, direction 1 turns on the leg A high side and the leg B low side (forward), and direction 0 turns on the leg A low side and the leg B high side (reverse). The mode input has no effect while enable is high.
- R2: With standby high, disable low and enable low, mode 1 turns on both high sides (brake) whatever the direction. Chop has no effect while enable is low.
- R3: With standby high, disable low, enable low, mode 0 and the zero-current flag low, direction 1 gives leg A low side and leg B high side, and direction 0 gives leg A high side and leg B low side (fast decay).
- R4: In the fast-decay state of R3, a high zero-current flag turns every switch off (both legs Hi-Z) at the next edge. The flag has no effect in any other state.
- R5: With enable and chop high, the leg that drive would turn high follows chop_lo_i (1 gives its low side, 0 gives its high side) and the other leg has its high side on. This is leg A in forward and leg B in reverse.
- R6: With standby low, both legs are Hi-Z at the next edge, whatever the other inputs are.
- R7: The high-side and low-side commands of one leg are never on in the same cycle.
- R8: A high disable input forces both legs to Hi-Z at the next edge. It overrides every other input.
- R9: When a leg changes from one switch to the other, both switches stay off for exactly DEAD_CYC cycles. A leg that has already been off for at least DEAD_CYC cycles turns a switch on at the next edge.
- R10: While rst_n is low, all switch commands are off and both Hi-Z flags are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stby_n_i | input | 1 | Standby, active low; low floats the bridge |
| disable_i | input | 1 | Protection shutdown; high floats the bridge |
| dir_i | input | 1 | Direction: 1 forward, 0 reverse |
| en_i | input | 1 | Drive enable |
| mode_i | input | 1 | Decay select when enable is low: 1 brake, 0 fast decay |
| chop_i | input | 1 | Current regulator chop request |
| chop_lo_i | input | 1 | Chop phase: 1 low side, 0 high side on the chopped leg |
| zero_i | input | 1 | Load current near zero |
| hs_o | output | 2 | High-side switch on, bit 0 leg A, bit 1 leg B |
| ls_o | output | 2 | Low-side switch on, bit 0 leg A, bit 1 leg B |
| hiz_o | output | 2 | Leg floating (both switches off), per leg |

## Verification
The bound checker watches every cycle for a leg with both switches on. It also checks that standby, disable and the zero-current release during fast decay float the bridge one edge later, and that no switch turns on after the opposite switch of its leg with fewer than DEAD_CYC off cycles between them. Which switch pattern each input combination selects, that the ignored inputs have no effect, and the exact length of the dead window can only be shown by the bench's stimulus table and directed sequences.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int N_LEGS = 2;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_e;
endpackage

// File: rtl/hbd_target_dec.sv
module hbd_target_dec
    import hbd_pkg::*;
(
    input  logic stby_n_i,
    input  logic disable_i,
    input  logic dir_i,
    input  logic en_i,
    input  logic mode_i,
    input  logic chop_i,
    input  logic chop_lo_i,
    input  logic zero_i,
    output leg_e tgt_o [N_LEGS]
);
    leg_e chopped;

    always_comb begin
        chopped = chop_lo_i ? LEG_LO : LEG_HI;
        tgt_o[0] = LEG_OFF;
        tgt_o[1] = LEG_OFF;
        if (disable_i || !stby_n_i) begin
            tgt_o[0] = LEG_OFF;
            tgt_o[1] = LEG_OFF;
        end else if (en_i) begin
            if (chop_i) begin
                tgt_o[0] = dir_i ? chopped : LEG_HI;
                tgt_o[1] = dir_i ? LEG_HI  : chopped;
            end else begin
                tgt_o[0] = dir_i ? LEG_HI : LEG_LO;
                tgt_o[1] = dir_i ? LEG_LO : LEG_HI;
            end
        end else if (mode_i) begin
            tgt_o[0] = LEG_HI;
            tgt_o[1] = LEG_HI;
        end else if (zero_i) begin
            tgt_o[0] = LEG_OFF;
            tgt_o[1] = LEG_OFF;
        end else begin
            tgt_o[0] = dir_i ? LEG_LO : LEG_HI;
            tgt_o[1] = dir_i ? LEG_HI : LEG_LO;
        end
    end
endmodule

// File: rtl/hbd_leg_seq.sv
module hbd_leg_seq
    import hbd_pkg::*;
#(
    parameter int DEAD_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  leg_e tgt_i,
    output logic hs_o,
    output logic ls_o,
    output logic hiz_o
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_W = CW'(DEAD_CYC);

    typedef struct packed {
        leg_e          st;
        logic [CW-1:0] cnt;
    } leg_reg_t;

    leg_reg_t leg_d, leg_q;

    always_comb begin
        leg_d = leg_q;
        if (tgt_i == LEG_OFF) begin
            leg_d.st = LEG_OFF;
            if (leg_q.st != LEG_OFF)
                leg_d.cnt = '0;
            else if (leg_q.cnt != DEAD_W)
                leg_d.cnt = leg_q.cnt + 1'b1;
        end else if (tgt_i == leg_q.st) begin
            leg_d.cnt = '0;
        end else if (leg_q.st != LEG_OFF) begin
            leg_d.st  = LEG_OFF;
            leg_d.cnt = '0;
        end else if (leg_q.cnt >= DEAD_W - 1'b1) begin
            leg_d.st  = tgt_i;
            leg_d.cnt = '0;
        end else begin
            leg_d.cnt = leg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_q.st  <= LEG_OFF;
            leg_q.cnt <= DEAD_W;
        end else begin
            leg_q <= leg_d;
        end
    end

    assign hs_o  = (leg_q.st == LEG_HI);
    assign ls_o  = (leg_q.st == LEG_LO);
    assign hiz_o = (leg_q.st == LEG_OFF);
endmodule

// File: rtl/hbridge_mode_decoder.sv
module hbridge_mode_decoder
    import hbd_pkg::*;
#(
    parameter int DEAD_CYC = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_n_i,
    input  logic              disable_i,
    input  logic              dir_i,
    input  logic              en_i,
    input  logic              mode_i,
    input  logic              chop_i,
    input  logic              chop_lo_i,
    input  logic              zero_i,
    output logic [N_LEGS-1:0] hs_o,
    output logic [N_LEGS-1:0] ls_o,
    output logic [N_LEGS-1:0] hiz_o
);
    leg_e tgt [N_LEGS];

    hbd_target_dec dec_i (
        .stby_n_i  (stby_n_i),
        .disable_i (disable_i),
        .dir_i     (dir_i),
        .en_i      (en_i),
        .mode_i    (mode_i),
        .chop_i    (chop_i),
        .chop_lo_i (chop_lo_i),
        .zero_i    (zero_i),
        .tgt_o     (tgt)
    );

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        hbd_leg_seq #(.DEAD_CYC(DEAD_CYC)) seq_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tgt_i (tgt[g]),
            .hs_o  (hs_o[g]),
            .ls_o  (ls_o[g]),
            .hiz_o (hiz_o[g])
        );
    end
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker
    import hbd_pkg::*;
#(
    parameter int DEAD_CYC = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stby_n_i,
    input logic              disable_i,
    input logic              en_i,
    input logic              mode_i,
    input logic              zero_i,
    input logic [N_LEGS-1:0] hs_o,
    input logic [N_LEGS-1:0] ls_o,
    input logic [N_LEGS-1:0] hiz_o
);
    localparam int OW = $clog2(DEAD_CYC + 2);

    // R7: never both switches of a leg
    p_no_shoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o & ls_o) == '0);

    p_standby_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n_i |=> (hiz_o == '1 && hs_o == '0 && ls_o == '0));

    p_disable_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (hiz_o == '1 && hs_o == '0 && ls_o == '0));

    p_zero_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_n_i && !disable_i && !en_i && !mode_i && zero_i) |=> (hiz_o == '1));

    for (genvar g = 0; g < N_LEGS; g++) begin : g_chk
        logic          hs_prev, ls_prev, last_hs, last_ls;
        logic [OW-1:0] off_run;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hs_prev <= 1'b0;
                ls_prev <= 1'b0;
                last_hs <= 1'b0;
                last_ls <= 1'b0;
                off_run <= '0;
            end else begin
                hs_prev <= hs_o[g];
                ls_prev <= ls_o[g];
                if (hs_o[g]) begin
                    last_hs <= 1'b1;
                    last_ls <= 1'b0;
                end else if (ls_o[g]) begin
                    last_hs <= 1'b0;
                    last_ls <= 1'b1;
                end
                if (hs_o[g] || ls_o[g])
                    off_run <= '0;
                else if (off_run != OW'(DEAD_CYC + 1))
                    off_run <= off_run + 1'b1;
            end
        end

        p_dead_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_o[g] && !hs_prev && last_ls) |-> (off_run >= OW'(DEAD_CYC)));

        p_dead_ls_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ls_o[g] && !ls_prev && last_hs) |-> (off_run >= OW'(DEAD_CYC)));
    end
endmodule

bind hbridge_mode_decoder hbd_checker #(.DEAD_CYC(DEAD_CYC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_n_i  (stby_n_i),
    .disable_i (disable_i),
    .en_i      (en_i),
    .mode_i    (mode_i),
    .zero_i    (zero_i),
    .hs_o      (hs_o),
    .ls_o      (ls_o),
    .hiz_o     (hiz_o)
);

// File: tb/hbridge_mode_decoder_tb_top.sv
module hbridge_mode_decoder_tb_top;
    localparam int DEAD = 18;
    localparam int NV   = 16;

    logic clk = 1'b0;
    logic rst_n, stby_n, dis, dir, en, mode, chop, chop_lo, zero;
    logic [1:0] hs, ls, hiz;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbridge_mode_decoder #(.DEAD_CYC(DEAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .stby_n_i(stby_n), .disable_i(dis),
        .dir_i(dir), .en_i(en), .mode_i(mode), .chop_i(chop),
        .chop_lo_i(chop_lo), .zero_i(zero),
        .hs_o(hs), .ls_o(ls), .hiz_o(hiz)
    );

    // {stby_n, dis, en, mode, dir, chop, chop_lo, zero, hs[1:0], ls[1:0]}
    localparam logic [11:0] VEC [NV] = '{
        12'b1_0_1_0_1_0_0_0_01_10, // R1 forward
        12'b1_0_1_0_0_0_0_0_10_01, // R1 reverse
        12'b1_0_0_1_1_0_0_0_11_00, // R2 brake dir1
        12'b1_0_0_1_0_0_0_0_11_00, // R2 brake dir0
        12'b1_0_0_1_1_0_0_1_11_00, // R4 zero ignored in brake
        12'b1_0_0_0_1_0_0_0_10_01, // R3 fast decay dir1
        12'b1_0_0_0_0_0_0_0_01_10, // R3 fast decay dir0
        12'b1_0_0_0_1_0_0_1_00_00, // R4 zero release
        12'b1_0_1_0_1_1_1_0_10_01, // R5 chop fwd low
        12'b1_0_1_0_1_1_0_0_11_00, // R5 chop fwd high
        12'b1_0_1_0_0_1_1_0_01_10, // R5 chop rev low
        12'b1_0_1_0_0_1_0_0_11_00, // R5 chop rev high
        12'b1_0_0_1_1_1_1_0_11_00, // R2 chop ignored when disabled drive
        12'b0_0_1_0_1_0_0_0_00_00, // R6 standby
        12'b1_1_0_1_1_0_0_0_00_00, // R8 disable over brake
        12'b1_0_1_1_1_0_0_0_01_10  // R1 mode ignored while enabled
    };

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [7:0] v);
        {stby_n, dis, en, mode, dir, chop, chop_lo, zero} = v;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(8'b0_0_0_0_0_0_0_0);
        edges(3);
        chk("R10 hs", hs, 2'b00);
        chk("R10 ls", ls, 2'b00);
        chk("R10 hiz", hiz, 2'b11);
        rst_n = 1'b1;
        edges(2);

        // R9: bridge already off long enough, turn-on at next edge
        drive(8'b1_0_1_0_1_0_0_0);
        edges(1);
        chk("R9 first on hs", hs, 2'b01);
        chk("R9 first on ls", ls, 2'b10);

        // R9: direction flip gives exactly DEAD off cycles
        dir = 1'b0;
        edges(1);
        chk("R9 dead start", hiz, 2'b11);
        edges(DEAD - 1);
        chk("R9 dead end", hiz, 2'b11);
        edges(1);
        chk("R9 after dead hs", hs, 2'b10);
        chk("R9 after dead ls", ls, 2'b01);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][11:4]);
            edges(DEAD + 4);
            chk($sformatf("vector %0d hs", k), hs, VEC[k][3:2]);
            chk($sformatf("vector %0d ls", k), ls, VEC[k][1:0]);
            chk($sformatf("R7 vector %0d overlap", k), hs & ls, 2'b00);
        end

        // R4: release during fast decay takes one edge
        drive(8'b1_0_0_0_1_0_0_0);
        edges(DEAD + 4);
        zero = 1'b1;
        edges(1);
        chk("R4 release", hiz, 2'b11);

        // R6: standby from forward drive takes one edge
        drive(8'b1_0_1_0_1_0_0_0);
        edges(DEAD + 4);
        stby_n = 1'b0;
        edges(1);
        chk("R6 standby", hiz, 2'b11);

        // R8: disable from reverse drive takes one edge
        drive(8'b1_0_1_0_0_0_0_0);
        edges(DEAD + 4);
        dis = 1'b1;
        edges(1);
        chk("R8 disable", hiz, 2'b11);

        // R10: reset from active drive
        drive(8'b1_0_0_1_0_0_0_0);
        edges(DEAD + 4);
        rst_n = 1'b0;
        edges(1);
        chk("R10 mid reset", hiz, 2'b11);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule